// File: doc/BRIEF.md
# Data Address Translation Checker

This block sits behind the translation lookup of a load/store pipeline. Each cycle it may take one data access (virtual address, access size, direction, and a few request qualifiers) together with the result the translation buffer produced for that address and the privilege state of the hart. One clock later it returns either a physical address with a cacheability flag, or a fault kind plus a six-bit memory-management status word that the exception logic copies into its syndrome.

The checks run in a fixed order. Alignment comes first. A physical-mode request skips translation. A kernel-only direct-map window converts the address without a lookup. Mapped accesses then go through the miss check, the per-mode permission check and the fault-on-read/write check. Every produced address is finally screened for bits beyond the implemented width, for the uncached half of the address map, and for the unimplemented register space.

Top module: `dat_xlat_check`

## Requirements
- R1: A misaligned access (size code s = 0..3 means 2^s bytes; misaligned when any of VA[s-1:0] is set) returns fault ALIGN (code 1) ahead of every other check, with only status bit 0 (write) set, and only when the access is a write.
- R2: The effective privilege (modes: kernel 0, executive 1, supervisor 2, user 3) is the current mode when the PC low bit is 0. When the PC low bit is 1, it is the alternate mode if the alternate flag is set and kernel otherwise. The alternate flag has no effect while the PC low bit is 0.
- R3: A physical-mode request uses VA as PA unchanged, and skips the VA validity check, the direct-map window and the lookup result.
- R4: A mapped request whose VA[63:48] is not all copies of VA[47] returns fault PAGE (code 2) with status bits 5 (bad VA) and 1 (access violation) set, plus bit 0 for writes.
- R5: VA[47:41] = 7'h7E selects the direct-map window. There the current mode (not the effective mode) must be kernel. Otherwise the fault is ACV (code 3) with status bit 1, plus bit 0 for writes.
- R6: A direct-map PA is VA[43:0] with bits 43:40 forced to ones when VA[40] is 1, and VA[39:0] otherwise. The lookup hit flag is ignored.
- R7: A mapped access that misses returns fault MISS (code 4), or MISS_PTE (code 5) when the request is a page-table access, with status bit 4 set plus bit 0 for writes.
- R8: On a hit, PA = (PPN << 13) + VA[12:0]. A write needs wr_en[eff_mode] and otherwise gives PAGE with status bits 0, 1 and, if fault-on-write is set, 3. A read needs rd_en[eff_mode] and otherwise gives ACV with status bit 1 and, if fault-on-read is set, 2.
- R9: When the permission check passes, fault-on-write (for writes) gives PAGE with status bits 0 and 3, and fault-on-read (for reads) gives PAGE with status bit 2 only. The other direction's bit is ignored.
- R10: A produced PA with any of bits 63:44 set returns fault MCHK (code 6) with zero status.
- R11: A produced PA with bit 43 set is reported uncached and has bits 42:35 cleared, and the remaining bits are kept.
- R12: A produced PA whose bits 43:32 are all ones (checked before clearing) returns fault UNIMP (code 7) with zero status.
- R13: The response is registered: rsp_vld_o follows req_vld_i one cycle later. On any fault PA and the uncached flag are zero. With no fault the status is zero. An idle cycle gives an all-zero response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_vld_i | input | 1 | Request present this cycle |
| req_va_i | input | 64 | Virtual address |
| req_size_i | input | 2 | Log2 of access size in bytes |
| req_wr_i | input | 1 | Access is a write |
| req_phys_i | input | 1 | Physical-mode request |
| req_alt_i | input | 1 | Use alternate mode under PC low bit |
| req_pte_i | input | 1 | Page-table access |
| pc_lsb_i | input | 1 | Low bit of the issuing PC |
| cur_mode_i | input | 2 | Current privilege mode |
| alt_mode_i | input | 2 | Alternate privilege mode |
| tlb_hit_i | input | 1 | Lookup found a matching entry |
| tlb_ppn_i | input | 32 | Physical page number of the entry |
| tlb_rd_en_i | input | 4 | Read enable per mode |
| tlb_wr_en_i | input | 4 | Write enable per mode |
| tlb_fonr_i | input | 1 | Fault-on-read flag of the entry |
| tlb_fonw_i | input | 1 | Fault-on-write flag of the entry |
| rsp_vld_o | output | 1 | Response valid |
| rsp_fault_o | output | 3 | Fault kind (0 none) |
| rsp_stat_o | output | 6 | Status bits |
| rsp_pa_o | output | 64 | Physical address |
| rsp_unc_o | output | 1 | Access is uncached |

## Verification
The hardest situations are those where two mode sources disagree. In one, the PC low bit promotes the effective mode to kernel while the current mode is user, and the access lands in the direct-map window, which must still fault because that window looks only at the current mode. In the other, the alternate flag is set without the PC low bit and must be ignored. The vector table sets up both by pairing entries whose permission masks admit exactly one mode, so a wrong mode choice flips the fault. Other entries reach the late screens (machine check, uncached clearing, register space) through physical-mode and hit addresses with bit patterns that separate each cleared or kept bit.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    localparam int ST_W = 6;

    localparam int ST_WR    = 0;
    localparam int ST_ACV   = 1;
    localparam int ST_FONR  = 2;
    localparam int ST_FONW  = 3;
    localparam int ST_MISS  = 4;
    localparam int ST_BADVA = 5;

    typedef enum logic [1:0] {
        MODE_KERN = 2'd0,
        MODE_EXEC = 2'd1,
        MODE_SUPV = 2'd2,
        MODE_USER = 2'd3
    } priv_e;

    typedef enum logic [2:0] {
        FLT_NONE     = 3'd0,
        FLT_ALIGN    = 3'd1,
        FLT_PAGE     = 3'd2,
        FLT_ACV      = 3'd3,
        FLT_MISS     = 3'd4,
        FLT_MISS_PTE = 3'd5,
        FLT_MCHK     = 3'd6,
        FLT_UNIMP    = 3'd7
    } fault_e;

endpackage

// File: rtl/xlat_mode_sel.sv
module xlat_mode_sel
    import xlat_pkg::*;
(
    input  logic  pc_lsb_i,
    input  logic  alt_sel_i,
    input  priv_e cur_mode_i,
    input  priv_e alt_mode_i,
    output priv_e eff_mode_o
);

    // R2: privileged-code mode override
    always_comb begin
        if (!pc_lsb_i) begin
            eff_mode_o = cur_mode_i;
        end else if (alt_sel_i) begin
            eff_mode_o = alt_mode_i;
        end else begin
            eff_mode_o = MODE_KERN;
        end
    end

endmodule

// File: rtl/xlat_va_class.sv
module xlat_va_class #(
    parameter int          VA_W     = 64,
    parameter int          SEXT_BIT = 47,
    parameter int          SP_LO    = 41,
    parameter int unsigned SP_TAG   = 32'h7E,
    parameter int          SZ_W     = 2
) (
    input  logic [VA_W-1:SP_LO]      va_hi_i,
    input  logic [(1<<SZ_W)-2:0]     va_lo_i,
    input  logic [SZ_W-1:0]          size_i,
    output logic                     misalign_o,
    output logic                     va_ok_o,
    output logic                     superpage_o
);

    localparam int TAG_W = SEXT_BIT - SP_LO + 1;
    localparam int HI_W  = VA_W - SEXT_BIT;
    localparam int LO_W  = (1 << SZ_W) - 1;

    logic [HI_W-1:0] sext_bits;
    logic [LO_W-1:0] low_mask;

    // R1: alignment mask built per size code
    for (genvar b = 0; b < LO_W; b++) begin : g_mask
        assign low_mask[b] = (32'(size_i) > b);
    end

    always_comb begin
        sext_bits   = va_hi_i[VA_W-1:SEXT_BIT];
        // R4: canonical when every upper bit copies the sign bit
        va_ok_o     = (sext_bits == '0) || (sext_bits == '1);
        // R5: direct-map window tag
        superpage_o = (va_hi_i[SEXT_BIT:SP_LO] == TAG_W'(SP_TAG));
        misalign_o  = |(va_lo_i & low_mask);
    end

endmodule

// File: rtl/xlat_pa_post.sv
module xlat_pa_post #(
    parameter int PA_W    = 64,
    parameter int IMPL_W  = 44,
    parameter int UNC_BIT = 43,
    parameter int CLR_LO  = 35,
    parameter int RS_LO   = 32
) (
    input  logic [PA_W-1:0] pa_i,
    output logic            mchk_o,
    output logic            unc_o,
    output logic            reg_space_o,
    output logic [PA_W-1:0] pa_o
);

    localparam logic [PA_W-1:0] IMPL_MASK = (PA_W'(1) << IMPL_W) - PA_W'(1);
    localparam logic [PA_W-1:0] CLR_MASK  =
        ((PA_W'(1) << UNC_BIT) - PA_W'(1)) & ~((PA_W'(1) << CLR_LO) - PA_W'(1));

    always_comb begin
        // R10: bits beyond the implemented width
        mchk_o      = |(pa_i & ~IMPL_MASK);
        // R11: uncached half of the map
        unc_o       = pa_i[UNC_BIT];
        // R12: register space judged on the raw address
        reg_space_o = &pa_i[UNC_BIT:RS_LO];
        pa_o        = unc_o ? (pa_i & ~CLR_MASK) : pa_i;
    end

endmodule

// File: rtl/dat_xlat_check.sv
module dat_xlat_check
    import xlat_pkg::*;
#(
    parameter int          VA_W       = 64,
    parameter int          PPN_W      = 32,
    parameter int          PAGE_SHIFT = 13,
    parameter int          IMPL_W     = 44,
    parameter int          SEXT_BIT   = 47,
    parameter int          SP_LO      = 41,
    parameter int unsigned SP_TAG     = 32'h7E,
    parameter int          SP_EXT_BIT = 40,
    parameter int          UNC_BIT    = 43,
    parameter int          CLR_LO     = 35,
    parameter int          RS_LO      = 32,
    parameter int          NMODE      = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             req_vld_i,
    input  logic [VA_W-1:0]  req_va_i,
    input  logic [1:0]       req_size_i,
    input  logic             req_wr_i,
    input  logic             req_phys_i,
    input  logic             req_alt_i,
    input  logic             req_pte_i,
    input  logic             pc_lsb_i,
    input  logic [1:0]       cur_mode_i,
    input  logic [1:0]       alt_mode_i,
    input  logic             tlb_hit_i,
    input  logic [PPN_W-1:0] tlb_ppn_i,
    input  logic [NMODE-1:0] tlb_rd_en_i,
    input  logic [NMODE-1:0] tlb_wr_en_i,
    input  logic             tlb_fonr_i,
    input  logic             tlb_fonw_i,
    output logic             rsp_vld_o,
    output logic [2:0]       rsp_fault_o,
    output logic [ST_W-1:0]  rsp_stat_o,
    output logic [VA_W-1:0]  rsp_pa_o,
    output logic             rsp_unc_o
);

    localparam logic [VA_W-1:0] IMPL_MASK   = (VA_W'(1) << IMPL_W) - VA_W'(1);
    localparam logic [VA_W-1:0] SP_LOW_MASK = (VA_W'(1) << SP_EXT_BIT) - VA_W'(1);
    localparam logic [VA_W-1:0] SP_EXT_MASK = IMPL_MASK & ~SP_LOW_MASK;
    localparam logic [VA_W-1:0] PG_MASK     = (VA_W'(1) << PAGE_SHIFT) - VA_W'(1);

    typedef struct packed {
        logic            vld;
        fault_e          fault;
        logic [ST_W-1:0] stat;
        logic [VA_W-1:0] pa;
        logic            unc;
    } rsp_t;

    rsp_t nxt_d, rsp_q;

    priv_e           cur_mode, alt_mode, eff_mode;
    logic            misalign, va_ok, in_sp, mapped;
    logic            rd_ok, wr_ok;
    logic [VA_W-1:0] sp_pa, hit_pa, pa_raw, pa_fin;
    logic            mchk, unc, reg_space;

    assign cur_mode = priv_e'(cur_mode_i);
    assign alt_mode = priv_e'(alt_mode_i);

    xlat_mode_sel u_mode (
        .pc_lsb_i   (pc_lsb_i),
        .alt_sel_i  (req_alt_i),
        .cur_mode_i (cur_mode),
        .alt_mode_i (alt_mode),
        .eff_mode_o (eff_mode)
    );

    xlat_va_class #(
        .VA_W     (VA_W),
        .SEXT_BIT (SEXT_BIT),
        .SP_LO    (SP_LO),
        .SP_TAG   (SP_TAG),
        .SZ_W     (2)
    ) u_class (
        .va_hi_i     (req_va_i[VA_W-1:SP_LO]),
        .va_lo_i     (req_va_i[2:0]),
        .size_i      (req_size_i),
        .misalign_o  (misalign),
        .va_ok_o     (va_ok),
        .superpage_o (in_sp)
    );

    // R6 and R8: candidate physical addresses
    always_comb begin
        if (req_va_i[SP_EXT_BIT]) begin
            sp_pa = (req_va_i & IMPL_MASK) | SP_EXT_MASK;
        end else begin
            sp_pa = req_va_i & SP_LOW_MASK;
        end
        hit_pa = (VA_W'(tlb_ppn_i) << PAGE_SHIFT) | (req_va_i & PG_MASK);
        if (req_phys_i) begin
            pa_raw = req_va_i;
        end else if (in_sp) begin
            pa_raw = sp_pa;
        end else begin
            pa_raw = hit_pa;
        end
        mapped = !req_phys_i && !in_sp;
        rd_ok  = tlb_rd_en_i[eff_mode];
        wr_ok  = tlb_wr_en_i[eff_mode];
    end

    xlat_pa_post #(
        .PA_W    (VA_W),
        .IMPL_W  (IMPL_W),
        .UNC_BIT (UNC_BIT),
        .CLR_LO  (CLR_LO),
        .RS_LO   (RS_LO)
    ) u_post (
        .pa_i        (pa_raw),
        .mchk_o      (mchk),
        .unc_o       (unc),
        .reg_space_o (reg_space),
        .pa_o        (pa_fin)
    );

    // Fixed-priority fault selection
    always_comb begin
        nxt_d     = '0;
        nxt_d.vld = req_vld_i;
        if (req_vld_i) begin
            if (misalign) begin
                nxt_d.fault            = FLT_ALIGN;
                nxt_d.stat[ST_WR]      = req_wr_i;
            end else if (!req_phys_i && !va_ok) begin
                nxt_d.fault            = FLT_PAGE;
                nxt_d.stat[ST_BADVA]   = 1'b1;
                nxt_d.stat[ST_ACV]     = 1'b1;
                nxt_d.stat[ST_WR]      = req_wr_i;
            end else if (!req_phys_i && in_sp && cur_mode != MODE_KERN) begin
                nxt_d.fault            = FLT_ACV;
                nxt_d.stat[ST_ACV]     = 1'b1;
                nxt_d.stat[ST_WR]      = req_wr_i;
            end else if (mapped && !tlb_hit_i) begin
                nxt_d.fault            = req_pte_i ? FLT_MISS_PTE : FLT_MISS;
                nxt_d.stat[ST_MISS]    = 1'b1;
                nxt_d.stat[ST_WR]      = req_wr_i;
            end else if (mapped && req_wr_i && !wr_ok) begin
                nxt_d.fault            = FLT_PAGE;
                nxt_d.stat[ST_WR]      = 1'b1;
                nxt_d.stat[ST_ACV]     = 1'b1;
                nxt_d.stat[ST_FONW]    = tlb_fonw_i;
            end else if (mapped && req_wr_i && tlb_fonw_i) begin
                nxt_d.fault            = FLT_PAGE;
                nxt_d.stat[ST_WR]      = 1'b1;
                nxt_d.stat[ST_FONW]    = 1'b1;
            end else if (mapped && !req_wr_i && !rd_ok) begin
                nxt_d.fault            = FLT_ACV;
                nxt_d.stat[ST_ACV]     = 1'b1;
                nxt_d.stat[ST_FONR]    = tlb_fonr_i;
            end else if (mapped && !req_wr_i && tlb_fonr_i) begin
                nxt_d.fault            = FLT_PAGE;
                nxt_d.stat[ST_FONR]    = 1'b1;
            end else if (mchk) begin
                nxt_d.fault            = FLT_MCHK;
            end else if (reg_space) begin
                nxt_d.fault            = FLT_UNIMP;
            end else begin
                nxt_d.pa               = pa_fin;
                nxt_d.unc              = unc;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= nxt_d;
        end
    end

    assign rsp_vld_o   = rsp_q.vld;
    assign rsp_fault_o = rsp_q.fault;
    assign rsp_stat_o  = rsp_q.stat;
    assign rsp_pa_o    = rsp_q.pa;
    assign rsp_unc_o   = rsp_q.unc;

endmodule

// File: rtl/dat_xlat_check_chk.sv
module dat_xlat_check_chk (
    input logic        clk_i,
    input logic        rst_ni,
    input logic        req_vld_i,
    input logic [63:0] req_va_i,
    input logic        req_wr_i,
    input logic        req_phys_i,
    input logic        rsp_vld_o,
    input logic [2:0]  rsp_fault_o,
    input logic [5:0]  rsp_stat_o,
    input logic [63:0] rsp_pa_o,
    input logic        rsp_unc_o
);

    // R1
    align_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rsp_fault_o == 3'd1) |-> (rsp_stat_o[5:1] == 5'd0 && rsp_stat_o[0] == $past(req_wr_i)));

    // R3
    phys_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rsp_vld_o && $past(req_phys_i) && rsp_fault_o == 3'd0 && !$past(req_va_i[43]))
        |-> (rsp_pa_o == $past(req_va_i)));

    // R4
    bad_va_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rsp_stat_o[5] |-> (rsp_fault_o == 3'd2 && rsp_stat_o[1] && rsp_stat_o[0] == $past(req_wr_i)));

    // R7
    miss_stat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rsp_fault_o == 3'd4 || rsp_fault_o == 3'd5) |-> (rsp_stat_o[4] && rsp_stat_o[5] == 1'b0 && rsp_stat_o[3:1] == 3'd0));

    // R10
    impl_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rsp_vld_o && rsp_fault_o == 3'd0) |-> (rsp_pa_o[63:44] == 20'd0));

    // R11
    unc_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rsp_unc_o |-> (rsp_pa_o[43] && rsp_pa_o[42:35] == 8'd0 && rsp_fault_o == 3'd0));

    // R13
    fault_clean_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rsp_fault_o != 3'd0) |-> (rsp_pa_o == 64'd0 && !rsp_unc_o));

    // R13
    ok_stat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rsp_fault_o == 3'd0) |-> (rsp_stat_o == 6'd0));

    // R13
    vld_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_vld_i |=> rsp_vld_o);

endmodule

bind dat_xlat_check dat_xlat_check_chk u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_vld_i   (req_vld_i),
    .req_va_i    (req_va_i),
    .req_wr_i    (req_wr_i),
    .req_phys_i  (req_phys_i),
    .rsp_vld_o   (rsp_vld_o),
    .rsp_fault_o (rsp_fault_o),
    .rsp_stat_o  (rsp_stat_o),
    .rsp_pa_o    (rsp_pa_o),
    .rsp_unc_o   (rsp_unc_o)
);

// File: tb/dat_xlat_check_test.sv
`timescale 1ns/1ps
module dat_xlat_check_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_vld = 1'b0;
    logic [63:0] req_va = '0;
    logic [1:0]  req_size = '0;
    logic        req_wr = 1'b0, req_phys = 1'b0, req_alt = 1'b0, req_pte = 1'b0, pc_lsb = 1'b0;
    logic [1:0]  cur_mode = '0, alt_mode = '0;
    logic        tlb_hit = 1'b0;
    logic [31:0] tlb_ppn = '0;
    logic [3:0]  tlb_rd_en = '0, tlb_wr_en = '0;
    logic        tlb_fonr = 1'b0, tlb_fonw = 1'b0;
    logic        rsp_vld;
    logic [2:0]  rsp_fault;
    logic [5:0]  rsp_stat;
    logic [63:0] rsp_pa;
    logic        rsp_unc;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dat_xlat_check uut (
        .clk_i (clk), .rst_ni (rst_n), .req_vld_i (req_vld), .req_va_i (req_va),
        .req_size_i (req_size), .req_wr_i (req_wr), .req_phys_i (req_phys),
        .req_alt_i (req_alt), .req_pte_i (req_pte), .pc_lsb_i (pc_lsb),
        .cur_mode_i (cur_mode), .alt_mode_i (alt_mode), .tlb_hit_i (tlb_hit),
        .tlb_ppn_i (tlb_ppn), .tlb_rd_en_i (tlb_rd_en), .tlb_wr_en_i (tlb_wr_en),
        .tlb_fonr_i (tlb_fonr), .tlb_fonw_i (tlb_fonw), .rsp_vld_o (rsp_vld),
        .rsp_fault_o (rsp_fault), .rsp_stat_o (rsp_stat), .rsp_pa_o (rsp_pa),
        .rsp_unc_o (rsp_unc)
    );

    // flag bits of a vector
    localparam logic [5:0] F_WR = 6'h01, F_PH = 6'h02, F_AL = 6'h04,
                           F_PT = 6'h08, F_PC = 6'h10, F_HT = 6'h20;

    typedef struct packed {
        logic [7:0]  rq;
        logic [63:0] va;
        logic [1:0]  sz;
        logic [5:0]  fl;
        logic [1:0]  cm;
        logic [1:0]  am;
        logic [31:0] ppn;
        logic [3:0]  rde;
        logic [3:0]  wre;
        logic [1:0]  fon;   // {fault-on-read, fault-on-write}
        logic [2:0]  ef;
        logic [5:0]  es;
        logic [63:0] epa;
        logic        eu;
    } vec_t;

    localparam int NV = 30;
    localparam vec_t VECS [NV] = '{
        // R1 misaligned word read
        '{8'd1, 64'h1002, 2'd2, 6'h00, 2'd3, 2'd0, 32'h0, 4'h0, 4'h0, 2'b00, 3'd1, 6'h00, 64'h0, 1'b0},
        // R1 misaligned half write
        '{8'd1, 64'h1001, 2'd1, F_WR, 2'd3, 2'd0, 32'h0, 4'h0, 4'h0, 2'b00, 3'd1, 6'h01, 64'h0, 1'b0},
        // R1 quad off by four, even on a hit
        '{8'd1, 64'h2464, 2'd3, F_HT, 2'd3, 2'd0, 32'h5, 4'hF, 4'hF, 2'b00, 3'd1, 6'h00, 64'h0, 1'b0},
        // R1 ahead of bad VA
        '{8'd1, 64'h0001_0000_0000_0001, 2'd1, 6'h00, 2'd3, 2'd0, 32'h0, 4'h0, 4'h0, 2'b00, 3'd1, 6'h00, 64'h0, 1'b0},
        // R8 hit read allowed
        '{8'd8, 64'h2468, 2'd3, F_HT, 2'd3, 2'd0, 32'h5, 4'b1000, 4'h0, 2'b00, 3'd0, 6'h00, 64'hA468, 1'b0},
        // R8 read denied, fonr echoed
        '{8'd8, 64'h2468, 2'd3, F_HT, 2'd3, 2'd0, 32'h5, 4'b0001, 4'h0, 2'b10, 3'd3, 6'h06, 64'h0, 1'b0},
        // R8 write denied, fonw echoed
        '{8'd8, 64'h2468, 2'd3, F_HT|F_WR, 2'd3, 2'd0, 32'h5, 4'h0, 4'b0001, 2'b01, 3'd2, 6'h0B, 64'h0, 1'b0},
        // R9 write allowed, fault-on-write
        '{8'd9, 64'h2468, 2'd3, F_HT|F_WR, 2'd3, 2'd0, 32'h5, 4'h0, 4'b1000, 2'b01, 3'd2, 6'h09, 64'h0, 1'b0},
        // R9 read allowed, fault-on-read
        '{8'd9, 64'h2468, 2'd3, F_HT, 2'd3, 2'd0, 32'h5, 4'b1000, 4'h0, 2'b10, 3'd2, 6'h04, 64'h0, 1'b0},
        // R9 write ignores fault-on-read
        '{8'd9, 64'h2468, 2'd3, F_HT|F_WR, 2'd3, 2'd0, 32'h5, 4'h0, 4'b1000, 2'b10, 3'd0, 6'h00, 64'hA468, 1'b0},
        // R7 plain read miss
        '{8'd7, 64'h2468, 2'd3, 6'h00, 2'd3, 2'd0, 32'h0, 4'hF, 4'hF, 2'b00, 3'd4, 6'h10, 64'h0, 1'b0},
        // R7 page-table write miss
        '{8'd7, 64'h2468, 2'd3, F_WR|F_PT, 2'd3, 2'd0, 32'h0, 4'hF, 4'hF, 2'b00, 3'd5, 6'h11, 64'h0, 1'b0},
        // R4 bad VA read
        '{8'd4, 64'h0001_0000_0000_0000, 2'd0, F_HT, 2'd3, 2'd0, 32'h0, 4'hF, 4'hF, 2'b00, 3'd2, 6'h22, 64'h0, 1'b0},
        // R4 bad VA write
        '{8'd4, 64'hFFFF_7FFF_FFFF_FFF0, 2'd0, F_WR, 2'd3, 2'd0, 32'h0, 4'hF, 4'hF, 2'b00, 3'd2, 6'h23, 64'h0, 1'b0},
        // R5 window from user, read
        '{8'd5, 64'hFFFF_FC00_0000_1000, 2'd3, 6'h00, 2'd3, 2'd0, 32'h0, 4'h0, 4'h0, 2'b00, 3'd3, 6'h02, 64'h0, 1'b0},
        // R5 window from user, write
        '{8'd5, 64'hFFFF_FC00_0000_1000, 2'd3, F_WR, 2'd3, 2'd0, 32'h0, 4'h0, 4'h0, 2'b00, 3'd3, 6'h03, 64'h0, 1'b0},
        // R5 PC low bit does not unlock the window
        '{8'd5, 64'hFFFF_FC00_0000_1000, 2'd3, F_PC, 2'd3, 2'd0, 32'h0, 4'h0, 4'h0, 2'b00, 3'd3, 6'h02, 64'h0, 1'b0},
        // R6 kernel window, bit 40 clear, hit ignored
        '{8'd6, 64'hFFFF_FC00_0000_1000, 2'd3, 6'h00, 2'd0, 2'd0, 32'h0, 4'h0, 4'h0, 2'b00, 3'd0, 6'h00, 64'h1000, 1'b0},
        // R6 kernel window, bit 40 set, extended then uncached
        '{8'd6, 64'hFFFF_FD00_0000_2000, 2'd3, 6'h00, 2'd0, 2'd0, 32'h0, 4'h0, 4'h0, 2'b00, 3'd0, 6'h00, 64'h0800_0000_2000, 1'b1},
        // R3 physical passthrough
        '{8'd3, 64'h1234_5678, 2'd0, F_PH, 2'd3, 2'd0, 32'h0, 4'h0, 4'h0, 2'b00, 3'd0, 6'h00, 64'h1234_5678, 1'b0},
        // R10 physical skips VA check, then machine check
        '{8'd10, 64'h0001_0000_0000_0000, 2'd0, F_PH, 2'd3, 2'd0, 32'h0, 4'h0, 4'h0, 2'b00, 3'd6, 6'h00, 64'h0, 1'b0},
        // R10 bit 44 set
        '{8'd10, 64'h0000_1000_0000_0000, 2'd0, F_PH, 2'd3, 2'd0, 32'h0, 4'h0, 4'h0, 2'b00, 3'd6, 6'h00, 64'h0, 1'b0},
        // R11 physical uncached clear
        '{8'd11, 64'h0000_08FF_8000_0040, 2'd0, F_PH, 2'd3, 2'd0, 32'h0, 4'h0, 4'h0, 2'b00, 3'd0, 6'h00, 64'h0000_0807_8000_0040, 1'b1},
        // R12 register space
        '{8'd12, 64'h0000_0FFF_0000_0000, 2'd0, F_PH, 2'd3, 2'd0, 32'h0, 4'h0, 4'h0, 2'b00, 3'd7, 6'h00, 64'h0, 1'b0},
        // R2 PC low bit gives kernel
        '{8'd2, 64'h2468, 2'd3, F_HT|F_PC, 2'd3, 2'd2, 32'h5, 4'b0001, 4'h0, 2'b00, 3'd0, 6'h00, 64'hA468, 1'b0},
        // R2 PC low bit with alternate flag gives alternate
        '{8'd2, 64'h2468, 2'd3, F_HT|F_PC|F_AL, 2'd3, 2'd2, 32'h5, 4'b0100, 4'h0, 2'b00, 3'd0, 6'h00, 64'hA468, 1'b0},
        // R2 alternate mode lacks read enable
        '{8'd2, 64'h2468, 2'd3, F_HT|F_PC|F_AL, 2'd3, 2'd2, 32'h5, 4'b0001, 4'h0, 2'b00, 3'd3, 6'h02, 64'h0, 1'b0},
        // R2 alternate flag ignored without PC low bit
        '{8'd2, 64'h2468, 2'd3, F_HT|F_AL, 2'd3, 2'd0, 32'h5, 4'b0001, 4'h0, 2'b00, 3'd3, 6'h02, 64'h0, 1'b0},
        // R10 hit page above implemented width
        '{8'd10, 64'h2468, 2'd3, F_HT, 2'd3, 2'd0, 32'h8000_0000, 4'hF, 4'hF, 2'b00, 3'd6, 6'h00, 64'h0, 1'b0},
        // R11 hit in uncached half
        '{8'd11, 64'h2468, 2'd3, F_HT, 2'd3, 2'd0, 32'h4000_0000, 4'hF, 4'hF, 2'b00, 3'd0, 6'h00, 64'h0000_0800_0000_0468, 1'b1}
    };

    task automatic drive(input vec_t v);
        req_vld   = 1'b1;
        req_va    = v.va;
        req_size  = v.sz;
        req_wr    = v.fl[0];
        req_phys  = v.fl[1];
        req_alt   = v.fl[2];
        req_pte   = v.fl[3];
        pc_lsb    = v.fl[4];
        tlb_hit   = v.fl[5];
        cur_mode  = v.cm;
        alt_mode  = v.am;
        tlb_ppn   = v.ppn;
        tlb_rd_en = v.rde;
        tlb_wr_en = v.wre;
        tlb_fonr  = v.fon[1];
        tlb_fonw  = v.fon[0];
    endtask

    task automatic check(input int rq, input logic [73:0] got, input logic [73:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL R%0d: got vld=%0b fault=%0d stat=%h pa=%h unc=%0b, expected vld=%0b fault=%0d stat=%h pa=%h unc=%0b",
                     rq, got[73], got[72:70], got[69:64], got[63:0] >> 0, rsp_unc,
                     exp[73], exp[72:70], exp[69:64], exp[63:0], 1'b0);
        end
    endtask

    task automatic check_vec(input vec_t v);
        checks++;
        if (!(rsp_vld === 1'b1 && rsp_fault === v.ef && rsp_stat === v.es &&
              rsp_pa === v.epa && rsp_unc === v.eu)) begin
            errors++;
            $display("FAIL R%0d: va=%h got fault=%0d stat=%h pa=%h unc=%0b vld=%0b, expected fault=%0d stat=%h pa=%h unc=%0b vld=1",
                     v.rq, v.va, rsp_fault, rsp_stat, rsp_pa, rsp_unc, rsp_vld,
                     v.ef, v.es, v.epa, v.eu);
        end
    endtask

    task automatic check_idle(input int rq);
        checks++;
        if (!(rsp_vld === 1'b0 && rsp_fault === 3'd0 && rsp_stat === 6'd0 &&
              rsp_pa === 64'd0 && rsp_unc === 1'b0)) begin
            errors++;
            $display("FAIL R%0d: got vld=%0b fault=%0d stat=%h pa=%h unc=%0b, expected all zero",
                     rq, rsp_vld, rsp_fault, rsp_stat, rsp_pa, rsp_unc);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // reset state (R13)
        check_idle(13);
        rst_n = 1'b1;
        @(negedge clk);
        check_idle(13);

        // table walk: inputs at one falling edge, response after the next rising edge
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            @(negedge clk);
            check_vec(VECS[i]);
        end

        // R13 idle cycle after traffic: a faulting request then nothing
        drive(VECS[0]);
        req_vld = 1'b0;
        @(negedge clk);
        check_idle(13);

        // R13 back-to-back: each response belongs to the request one cycle earlier
        drive(VECS[4]);
        @(negedge clk);
        check_vec(VECS[4]);
        drive(VECS[20]);
        @(negedge clk);
        check_vec(VECS[20]);
        req_vld = 1'b0;
        @(negedge clk);
        check_idle(13);

        // R13 reset in mid-stream clears the response
        drive(VECS[22]);
        rst_n = 1'b0;
        @(negedge clk);
        check_idle(13);
        rst_n = 1'b1;
        req_vld = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got run still active, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule